// File: doc/BRIEF.md
# Buffered Serial Sample Output Port

This block collects filtered samples and sends them to a communications controller over a serial link. On each sample-valid strobe it joins the 24-bit sample and its 8-bit status byte into one 32-bit word. It places that word in an eight-entry first-in first-out queue. It then sends one queued word per transaction on a serial clock and serial data pair, most significant bit first.

A transaction starts only on a handshake from the controller. In continuous mode, a rising edge on the token input starts a transaction whenever the queue holds a word. In requested mode, a rising edge on the poll input starts one. The port drives its ready flag low from the start of a transfer until its last bit, so that outside logic can use ready to gate the token off. Both handshake inputs pass through a two-flop synchronizer and are edge-detected in the system clock domain.

The controller is a four-state machine:
- `ST_IDLE` waits for a qualified edge and takes the transition *start* to `ST_LOAD`.
- `ST_LOAD` pops the queue into the shift register and takes *load* to `ST_LOW`.
- `ST_LOW` holds the serial clock low with the bit on the line, and takes *rise* to `ST_HIGH` after `HALF_CYC` cycles.
- `ST_HIGH` holds the serial clock high. After `HALF_CYC` cycles it takes *next* back to `ST_LOW`, or *finish* to `ST_IDLE` once the 32nd bit is done.

Top module: `sample_out_port`

## Requirements
- R1: Each transaction sends exactly 32 bits, one per rising edge of `sclk`. The bits are the 24-bit sample in bits 31..8 and the status byte in bits 7..0, sent from bit 31 down to bit 0.
- R2: Up to 8 words are held in the queue and sent in the order they were written.
- R3: With `req_mode` = 0 (continuous), a rising edge on `token_in` starts a transaction when the queue is not empty. When the queue is empty, the edge has no effect.
- R4: With `req_mode` = 1 (requested), a rising edge on `poll_in` starts one transaction, and `token_in` has no effect. With `req_mode` = 0, `poll_in` has no effect. A poll with an empty queue is ignored and `ready` stays high.
- R5: `ready` is low for the whole transaction, including every rising edge of `sclk`. It returns high by itself once the last bit is done.
- R6: Handshake edges that arrive while a transaction is in progress are ignored. They do not start an extra transaction.
- R7: A write while the queue is full drops the new word and sets `overflow`. `overflow` then stays set until reset.
- R8: While no transaction is in progress (`ready` high), `sclk` and `sdata` are both low.
- R9: Within a transaction, rising edges of `sclk` are `2*HALF_CYC` system clocks apart. `sdata` does not change while `sclk` is high.
- R10: After reset, `ready` is 1, `sclk` is 0, `sdata` is 0, `overflow` is 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe: write the sample and status into the queue |
| smp_data | input | 24 | Filtered sample |
| smp_status | input | 8 | Status byte that goes with the sample |
| req_mode | input | 1 | 0 = continuous (token-driven), 1 = requested (poll-driven) |
| token_in | input | 1 | Asynchronous token; a rising edge starts a transfer in continuous mode |
| poll_in | input | 1 | Asynchronous poll; a rising edge starts a transfer in requested mode |
| ready | output | 1 | High when idle; low for the duration of a transfer |
| sclk | output | 1 | Serial clock; data is meant to be sampled on its rising edge |
| sdata | output | 1 | Serial data, most significant bit first |
| overflow | output | 1 | Sticky flag: a word was dropped because the queue was full |

## Verification
The bound assertions check the following on every cycle:
- the serial lines stay quiet while `ready` is high;
- `sdata` holds steady across each high phase of `sclk`;
- the overflow flag is set after a write into a full queue, and stays set;
- an empty queue never lets a transfer begin;
- each transfer ends after exactly 32 clock edges.

Some behaviour can only be shown by the bench's scenarios. These are:
- the bit order and the packing of sample and status;
- the first-in first-out order across the eight slots;
- the choice between token and poll by mode;
- the rejection of handshake edges that arrive mid-transfer;
- the dropping of words past the eighth.

// File: rtl/sample_out_pkg.sv
package sample_out_pkg;

    localparam int SAMPLE_W = 24;
    localparam int STATUS_W = 8;
    localparam int WORD_W   = SAMPLE_W + STATUS_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LOW,
        ST_HIGH
    } tx_state_t;

    function automatic logic [WORD_W-1:0] pack_word(
        input logic [SAMPLE_W-1:0] smp,
        input logic [STATUS_W-1:0] sts
    );
        return {smp, sts};
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr;
    logic [AW:0]      rd_ptr;

    assign empty   = (wr_ptr == rd_ptr);
    assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign rd_data = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en && !full) begin
            mem[wr_ptr[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en && !full) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (rd_en && !empty) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sample_out_port.sv
module sample_out_port
    import sample_out_pkg::*;
#(
    parameter int FIFO_DEPTH  = 8,
    parameter int HALF_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [STATUS_W-1:0] smp_status,
    input  logic                req_mode,
    input  logic                token_in,
    input  logic                poll_in,
    output logic                ready,
    output logic                sclk,
    output logic                sdata,
    output logic                overflow
);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int HALF_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF_CYC - 1);

    tx_state_t         state_q, state_d;
    logic [WORD_W-1:0] shreg_q;
    logic [BIT_W-1:0]  bit_q;
    logic [HALF_W-1:0] half_q;
    logic              half_done;
    logic              token_rise, poll_rise, start_req;
    logic              fifo_full, fifo_empty;
    logic [WORD_W-1:0] fifo_rd;
    logic              overflow_q;

    // Handshake synchronizers
    edge_sync #(.STAGES(SYNC_STAGES)) u_tok_sync (
        .clk(clk), .rst_n(rst_n), .async_in(token_in), .rise(token_rise)
    );
    edge_sync #(.STAGES(SYNC_STAGES)) u_poll_sync (
        .clk(clk), .rst_n(rst_n), .async_in(poll_in), .rise(poll_rise)
    );

    word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (smp_valid),
        .wr_data (pack_word(smp_data, smp_status)),
        .rd_en   (state_q == ST_LOAD),
        .rd_data (fifo_rd),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    assign start_req = !fifo_empty && (req_mode ? poll_rise : token_rise);
    assign half_done = (half_q == HALF_LAST);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_LOW;
            ST_LOW:  if (half_done) state_d = ST_HIGH;
            ST_HIGH: if (half_done) state_d = (bit_q == LAST_BIT) ? ST_IDLE : ST_LOW;
            default: state_d = ST_IDLE;
        endcase
    end

    // Shift datapath and phase timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_q   <= '0;
            half_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    half_q <= '0;
                end
                ST_LOAD: begin
                    shreg_q <= fifo_rd;
                    bit_q   <= '0;
                    half_q  <= '0;
                end
                ST_LOW: begin
                    half_q <= half_done ? '0 : half_q + 1'b1;
                end
                ST_HIGH: begin
                    half_q <= half_done ? '0 : half_q + 1'b1;
                    if (half_done && bit_q != LAST_BIT) begin
                        shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                        bit_q   <= bit_q + 1'b1;
                    end
                end
                default: half_q <= '0;
            endcase
        end
    end

    // Sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow_q <= 1'b0;
        end else if (smp_valid && fifo_full) begin
            overflow_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        ready    = 1'b0;
        sclk     = 1'b0;
        sdata    = 1'b0;
        overflow = overflow_q;
        unique case (state_q)
            ST_IDLE: ready = 1'b1;
            ST_LOAD: ready = 1'b0;
            ST_LOW:  sdata = shreg_q[WORD_W-1];
            ST_HIGH: begin
                sclk  = 1'b1;
                sdata = shreg_q[WORD_W-1];
            end
            default: ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/sample_out_port_chk.sv
module sample_out_port_chk (
    input logic clk,
    input logic rst_n,
    input logic ready,
    input logic sclk,
    input logic sdata,
    input logic overflow,
    input logic smp_valid,
    input logic fifo_full,
    input logic fifo_empty
);
    logic [6:0] edge_cnt;
    logic       sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            sclk_q   <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (ready) begin
                edge_cnt <= '0;
            end else if (sclk && !sclk_q) begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ready |-> (!sclk && !sdata)); // R8
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) (sclk && sclk_q) |-> $stable(sdata)); // R9
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) (smp_valid && fifo_full) |=> overflow); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R7
    AST_EMPTY_NO_START: assert property (@(posedge clk) disable iff (!rst_n) (ready && fifo_empty) |=> ready); // R3
    AST_WORD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) (ready && !$past(ready)) |-> (edge_cnt == 7'd32)); // R1
    AST_BUSY_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> !ready); // R5
endmodule

bind sample_out_port sample_out_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .sclk       (sclk),
    .sdata      (sdata),
    .overflow   (overflow),
    .smp_valid  (smp_valid),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty)
);

// File: tb/sample_out_port_test.sv
module sample_out_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic [7:0]  smp_status = '0;
    logic        req_mode = 1'b0;
    logic        token_in = 1'b0;
    logic        poll_in = 1'b0;
    logic        ready, sclk, sdata, overflow;

    int n_chk = 0;
    int n_bad = 0;
    int tx_count = 0;
    logic [31:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sample_out_port #(.HALF_CYC(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_status(smp_status), .req_mode(req_mode), .token_in(token_in),
        .poll_in(poll_in), .ready(ready), .sclk(sclk), .sdata(sdata),
        .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Monitor: rebuild each word from rising sclk edges and compare
    initial begin
        logic        prev_sclk = 1'b0;
        logic [31:0] word = '0;
        int          nbits = 0;
        int          gap = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev_sclk = 1'b0; nbits = 0; gap = 0;
            end else begin
                gap++;
                if (ready) begin
                    chk(!sclk && !sdata, "R8", {30'd0, sclk, sdata}, 32'd0);
                end
                if (sclk && !prev_sclk) begin
                    chk(!ready, "R5", {31'd0, ready}, 32'd0);
                    if (nbits > 0) chk(gap == 2*HALF, "R9", gap, 2*HALF);
                    gap = 0;
                    word = {word[30:0], sdata};
                    nbits++;
                    if (nbits == 32) begin
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R2", word, 32'hxxxxxxxx);
                        end else begin
                            logic [31:0] e;
                            e = exp_q.pop_front();
                            chk(word == e, "R1", word, e);
                        end
                        nbits = 0;
                        tx_count++;
                    end
                end
                prev_sclk = sclk;
            end
        end
    end

    task automatic write_word(input logic [23:0] s, input logic [7:0] st, input bit keep);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = s; smp_status = st;
        @(negedge clk);
        smp_valid = 1'b0;
        if (keep) exp_q.push_back({s, st});
    endtask

    task automatic pulse_token();
        token_in = 1'b1;
        repeat (4) @(negedge clk);
        token_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_poll();
        poll_in = 1'b1;
        repeat (4) @(negedge clk);
        poll_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_tx(input int target);
        for (int i = 0; i < 400 && tx_count < target; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        chk(ready === 1'b1 && sclk === 1'b0 && sdata === 1'b0 && overflow === 1'b0,
            "R10", {28'd0, ready, sclk, sdata, overflow}, 32'h8);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: token with empty queue does nothing
        pulse_token();
        repeat (20) @(negedge clk);
        chk(tx_count == 0 && ready, "R3", tx_count, 0);

        // R1 R2 R3: three words, token-driven
        write_word(24'hA5C31F, 8'h81, 1'b1);
        write_word(24'h000001, 8'hFE, 1'b1);
        write_word(24'h800000, 8'h00, 1'b1);
        for (int k = 1; k <= 3; k++) begin
            pulse_token();
            wait_tx(k);
            chk(ready == 1'b1, "R5", {31'd0, ready}, 1);
        end
        chk(tx_count == 3, "R2", tx_count, 3);

        // R6: edges during a transfer ignored
        write_word(24'h123456, 8'h78, 1'b1);
        write_word(24'hFEDCBA, 8'h98, 1'b1);
        pulse_token();
        repeat (20) @(negedge clk);
        chk(!ready, "R6", {31'd0, ready}, 0);
        pulse_token();
        wait_tx(4);
        repeat (200) @(negedge clk);
        chk(tx_count == 4, "R6", tx_count, 4);
        pulse_token();
        wait_tx(5);
        chk(tx_count == 5, "R6", tx_count, 5);

        // R4: poll ignored in continuous mode
        write_word(24'h0F0F0F, 8'h3C, 1'b1);
        pulse_poll();
        repeat (20) @(negedge clk);
        chk(tx_count == 5 && ready, "R4", tx_count, 5);
        pulse_token();
        wait_tx(6);
        chk(tx_count == 6, "R4", tx_count, 6);

        // R4: requested mode, token ignored, poll works
        req_mode = 1'b1;
        write_word(24'h5A5A5A, 8'hC3, 1'b1);
        pulse_token();
        repeat (20) @(negedge clk);
        chk(tx_count == 6 && ready, "R4", tx_count, 6);
        pulse_poll();
        wait_tx(7);
        chk(tx_count == 7, "R4", tx_count, 7);

        // R7 R2: overflow on ninth and tenth writes
        for (int k = 0; k < 10; k++) begin
            write_word(24'(32'h100000 + k * 32'h011111), 8'(k), k < 8);
        end
        chk(overflow == 1'b1, "R7", {31'd0, overflow}, 1);
        base = tx_count;
        for (int k = 1; k <= 8; k++) begin
            pulse_poll();
            wait_tx(base + k);
        end
        chk(tx_count == base + 8, "R2", tx_count, base + 8);
        chk(exp_q.size() == 0, "R2", exp_q.size(), 0);

        // R4: poll with empty queue ignored
        pulse_poll();
        repeat (30) @(negedge clk);
        chk(tx_count == base + 8 && ready, "R4", tx_count, base + 8);
        chk(overflow == 1'b1, "R7", {31'd0, overflow}, 1);

        // R7 R10: reset clears overflow
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(overflow == 1'b0 && ready, "R10", {30'd0, ready, overflow}, 32'h2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule